// File: doc/BRIEF.md
# Calibrated Unipolar/Bipolar Code Formatter

This block turns each signed result from a converter's decimation filter into the final 16-bit output word. Two calibration measurements set the scaling. The first is a zero-point reading, which becomes the offset. The second is a full-scale reading, which sets a gain slope. The slope is the reciprocal of the span between the two readings. A restoring divider computes it one quotient bit per cycle.

A mode pin selects the output coding. Straight binary is used for single-ended ranges, and offset binary for ranges that include negative inputs. Both codings use the same pair of coefficients, so changing mode needs no new calibration. In offset-binary mode, 8000h is added after scaling, so the negative side of the transfer line carries on with the same slope.

The mode pin is sampled in the cycle a result is accepted. The finished word is written to the output a fixed number of cycles later. This lets the mode pin change between conversions without a latch further upstream.

Top module: `cal_code_formatter`

## Requirements
- R1: After reset, `out_valid`, `cal_busy`, `cal_err` and `out_code` are 0. The coefficients are offset 0 and slope 2^16, so before any calibration a result is passed through unscaled and then coded.
- R2: A `cal_zero_valid` pulse stores `cal_raw` as the candidate offset. A later `cal_fs_valid` pulse, with `cal_raw` greater than the candidate, computes slope = floor(2^32 / (full-scale − candidate)). When that finishes, the candidate becomes the offset and the new slope is installed.
- R3: `cal_busy` rises the cycle after an accepted full-scale pulse and stays high for exactly 34 cycles. While it is high, `raw_valid`, `cal_zero_valid` and `cal_fs_valid` are ignored.
- R4: A full-scale pulse whose value is less than or equal to the candidate offset sets `cal_err` and keeps the old coefficients. The next accepted full-scale pulse clears `cal_err`.
- R5: The scaled value is floor(((raw − offset) × slope + 2^15) / 2^16), saturated to the 18-bit signed range [−131072, 131071].
- R6: With `bipolar` = 0 the code is the scaled value, clamped to 0000h..FFFFh.
- R7: With `bipolar` = 1 the code is the scaled value plus 8000h, clamped to 0000h..FFFFh. A raw value equal to the offset gives 8000h. Both modes use the same coefficients.
- R8: `bipolar` is sampled in the cycle `raw_valid` is accepted, and later changes to it have no effect on that result. `out_valid` pulses for one cycle exactly 82 cycles after acceptance. `out_code` changes only together with `out_valid`.
- R9: If a second result is accepted before the first one is written, the first is dropped. Only the second is written, 82 cycles after it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_zero_valid | input | 1 | Pulse: `cal_raw` holds the zero-point reading |
| cal_fs_valid | input | 1 | Pulse: `cal_raw` holds the full-scale reading |
| cal_raw | input | RAW_W (20) | Signed calibration reading |
| raw_valid | input | 1 | Pulse: `raw_result` holds a new filter result |
| raw_result | input | RAW_W (20) | Signed filter result |
| bipolar | input | 1 | 0 = straight binary, 1 = offset binary |
| cal_busy | output | 1 | Slope division in progress |
| cal_err | output | 1 | Last full-scale reading was not above the offset |
| out_valid | output | 1 | One-cycle pulse when `out_code` is updated |
| out_code | output | OUT_W (16) | Formatted output word |

## Verification
The assertions assume that every valid input is a single-cycle pulse. They also assume a fresh calibration begins only after the sequencer has offered a zero reading, since the full-scale span is taken from whatever candidate is stored. The stimulus drives every strobe for exactly one cycle from the falling edge. It sends calibration pairs in zero-then-full-scale order, except in the test that sends a full-scale reading alone to show that a zero reading during division was ignored. Mode changes are applied only after a result has been accepted, or during a division, where the block must ignore them.

// File: rtl/calfmt_pkg.sv
package calfmt_pkg;

  typedef enum logic {
    CODE_STRAIGHT = 1'b0,
    CODE_OFFSET   = 1'b1
  } code_mode_e;

endpackage

// File: rtl/slope_divider.sv
module slope_divider #(
  parameter int DEN_W   = 21,
  parameter int NUM_EXP = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [DEN_W-1:0]   den,
  output logic               busy,
  output logic               done,
  output logic [NUM_EXP:0]   quot
);
  localparam int QW = NUM_EXP + 1;
  localparam int CW = $clog2(QW + 1);

  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem_q;
  logic [CW-1:0]    left_q;
  logic             num_bit;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   less;
  logic             fits;

  // The dividend is a single one at bit NUM_EXP; it enters on the first step.
  always_comb begin
    num_bit = (left_q == CW'(QW));
    trial   = {rem_q, num_bit};
    fits    = (trial >= {1'b0, den_q});
    less    = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      den_q  <= '0;
      rem_q  <= '0;
      left_q <= '0;
      quot   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        den_q  <= den;
        rem_q  <= '0;
        left_q <= CW'(QW);
        quot   <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        if (fits) rem_q <= less[DEN_W-1:0];
        else      rem_q <= trial[DEN_W-1:0];
        quot   <= {quot[QW-2:0], fits};
        left_q <= left_q - CW'(1);
        if (left_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/code_scaler.sv
module code_scaler
  import calfmt_pkg::*;
#(
  parameter int RAW_W   = 20,
  parameter int SLOPE_W = 33,
  parameter int OUT_W   = 16,
  parameter int FRAC    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic signed [RAW_W-1:0] raw,
  input  logic signed [RAW_W-1:0] off,
  input  logic [SLOPE_W-1:0]      slope,
  input  logic                    mode,
  output logic [OUT_W-1:0]        code
);
  localparam int PW    = RAW_W + 1 + SLOPE_W + 1;
  localparam int SAT_W = OUT_W + 2;

  logic signed [RAW_W:0]   diff_q;
  logic [SLOPE_W-1:0]      slope_q;
  code_mode_e              mode_q;
  logic signed [PW-1:0]    prod_q;

  logic signed [PW-1:0]    a_ext, b_ext;
  logic signed [SLOPE_W:0] slope_s;
  logic signed [PW-1:0]    half, sum, rounded, sat_hi, sat_lo;
  logic signed [SAT_W-1:0] sat_v;
  logic signed [SAT_W:0]   ext_v, bias_v, biased, code_max;

  // Stage 1: difference from the offset, mode and slope captured together.
  always_ff @(posedge clk) begin
    if (rst) begin
      diff_q  <= '0;
      slope_q <= '0;
      mode_q  <= CODE_STRAIGHT;
    end else if (take) begin
      diff_q  <= {raw[RAW_W-1], raw} - {off[RAW_W-1], off};
      slope_q <= slope;
      mode_q  <= code_mode_e'(mode);
    end
  end

  always_comb begin
    slope_s = {1'b0, slope_q};
    a_ext   = PW'(diff_q);
    b_ext   = PW'(slope_s);
  end

  // Stage 2: full-width product.
  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= a_ext * b_ext;
  end

  // Stage 3 (combinational, read when the write timer fires).
  always_comb begin
    half     = PW'(1) << (FRAC - 1);
    sum      = prod_q + half;
    rounded  = sum >>> FRAC;
    sat_hi   = PW'(2 ** (SAT_W - 1) - 1);
    sat_lo   = -sat_hi - PW'(1);
    if (rounded > sat_hi)      sat_v = sat_hi[SAT_W-1:0];
    else if (rounded < sat_lo) sat_v = sat_lo[SAT_W-1:0];
    else                       sat_v = rounded[SAT_W-1:0];
    ext_v    = {sat_v[SAT_W-1], sat_v};
    bias_v   = (mode_q == CODE_OFFSET) ? (SAT_W+1)'(2 ** (OUT_W - 1)) : '0;
    biased   = ext_v + bias_v;
    code_max = (SAT_W+1)'(2 ** OUT_W - 1);
    if (biased < 0)             code = '0;
    else if (biased > code_max) code = '1;
    else                        code = biased[OUT_W-1:0];
  end
endmodule

// File: rtl/write_timer.sv
module write_timer #(
  parameter int LEAD = 82
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);
  localparam int TW = $clog2(LEAD + 1);

  logic [TW-1:0] left_q;

  always_comb fire = (left_q == TW'(1)) && !start;

  always_ff @(posedge clk) begin
    if (rst)                 left_q <= '0;
    else if (start)          left_q <= TW'(LEAD);
    else if (left_q != '0)   left_q <= left_q - TW'(1);
  end
endmodule

// File: rtl/cal_code_formatter.sv
module cal_code_formatter #(
  parameter int RAW_W     = 20,
  parameter int OUT_W     = 16,
  parameter int SLOPE_EXP = 32,
  parameter int MODE_LEAD = 82
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cal_zero_valid,
  input  logic                    cal_fs_valid,
  input  logic signed [RAW_W-1:0] cal_raw,
  input  logic                    raw_valid,
  input  logic signed [RAW_W-1:0] raw_result,
  input  logic                    bipolar,
  output logic                    cal_busy,
  output logic                    cal_err,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_code
);
  localparam int DEN_W   = RAW_W + 1;
  localparam int SLOPE_W = SLOPE_EXP + 1;
  localparam int FRAC    = SLOPE_EXP - OUT_W;

  logic signed [RAW_W-1:0] off_q, cand_q, pend_q;
  logic [SLOPE_W-1:0]      slope_q;
  logic                    accept_zero, accept_fs, span_ok, div_start, take;
  logic [DEN_W-1:0]        span;
  logic                    div_busy, div_done, fire;
  logic [SLOPE_W-1:0]      div_quot;
  logic [OUT_W-1:0]        code;

  always_comb begin
    accept_zero = cal_zero_valid && !cal_busy;
    accept_fs   = cal_fs_valid && !cal_busy;
    span_ok     = cal_raw > cand_q;
    div_start   = accept_fs && span_ok;
    span        = {cal_raw[RAW_W-1], cal_raw} - {cand_q[RAW_W-1], cand_q};
    take        = raw_valid && !cal_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q    <= '0;
      cand_q   <= '0;
      pend_q   <= '0;
      slope_q  <= SLOPE_W'(1) << FRAC;
      cal_busy <= 1'b0;
      cal_err  <= 1'b0;
    end else begin
      if (accept_zero) cand_q <= cal_raw;
      if (accept_fs) begin
        if (span_ok) begin
          cal_busy <= 1'b1;
          cal_err  <= 1'b0;
          pend_q   <= cand_q;
        end else begin
          cal_err  <= 1'b1;
        end
      end
      if (div_done) begin
        cal_busy <= 1'b0;
        off_q    <= pend_q;
        slope_q  <= div_quot;
      end
    end
  end

  slope_divider #(.DEN_W(DEN_W), .NUM_EXP(SLOPE_EXP)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .den(span),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  code_scaler #(.RAW_W(RAW_W), .SLOPE_W(SLOPE_W), .OUT_W(OUT_W), .FRAC(FRAC)) u_scale (
    .clk(clk), .rst(rst), .take(take), .raw(raw_result), .off(off_q),
    .slope(slope_q), .mode(bipolar), .code(code)
  );

  write_timer #(.LEAD(MODE_LEAD)) u_timer (
    .clk(clk), .rst(rst), .start(take), .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_code <= code;
    end
  end
endmodule

// File: rtl/cal_code_formatter_chk.sv
module cal_code_formatter_chk #(
  parameter int RAW_W     = 20,
  parameter int OUT_W     = 16,
  parameter int SLOPE_EXP = 32,
  parameter int MODE_LEAD = 82
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cal_zero_valid,
  input logic                    cal_fs_valid,
  input logic signed [RAW_W-1:0] cal_raw,
  input logic                    raw_valid,
  input logic signed [RAW_W-1:0] raw_result,
  input logic                    bipolar,
  input logic                    cal_busy,
  input logic                    cal_err,
  input logic                    out_valid,
  input logic [OUT_W-1:0]        out_code
);
  localparam int SW       = $clog2(MODE_LEAD + 2);
  localparam int BUSY_LEN = SLOPE_EXP + 2;
  localparam int BW       = $clog2(BUSY_LEN + 2);

  logic [SW-1:0] since_q;
  logic          seen_q;
  logic [BW-1:0] busy_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q    <= '0;
      seen_q     <= 1'b0;
      busy_len_q <= '0;
    end else begin
      if (raw_valid && !cal_busy) begin
        since_q <= '0;
        seen_q  <= 1'b1;
      end else if (since_q != SW'(MODE_LEAD + 1)) begin
        since_q <= since_q + SW'(1);
      end
      if (!cal_busy)                          busy_len_q <= '0;
      else if (busy_len_q != BW'(BUSY_LEN+1)) busy_len_q <= busy_len_q + BW'(1);
    end
  end

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_write_lead_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen_q && since_q == SW'(MODE_LEAD)));

  p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_code) |-> out_valid);

  p_busy_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy) |-> $past(cal_fs_valid));

  p_busy_length_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cal_busy) |-> busy_len_q == BW'(BUSY_LEN));

  p_err_cause_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_err) |-> $past(cal_fs_valid && !cal_busy));

  p_err_clear_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy) |-> !cal_err);
endmodule

bind cal_code_formatter cal_code_formatter_chk #(
  .RAW_W(RAW_W), .OUT_W(OUT_W), .SLOPE_EXP(SLOPE_EXP), .MODE_LEAD(MODE_LEAD)
) u_chk (
  .clk(clk), .rst(rst), .cal_zero_valid(cal_zero_valid), .cal_fs_valid(cal_fs_valid),
  .cal_raw(cal_raw), .raw_valid(raw_valid), .raw_result(raw_result), .bipolar(bipolar),
  .cal_busy(cal_busy), .cal_err(cal_err), .out_valid(out_valid), .out_code(out_code)
);

// File: tb/cal_code_formatter_test.sv
module cal_code_formatter_test;
  localparam int RAW_W     = 20;
  localparam int OUT_W     = 16;
  localparam int SLOPE_EXP = 32;
  localparam int MODE_LEAD = 82;

  logic clk = 1'b0;
  logic rst;
  logic cal_zero_valid, cal_fs_valid, raw_valid, bipolar;
  logic signed [RAW_W-1:0] cal_raw, raw_result;
  logic cal_busy, cal_err, out_valid;
  logic [OUT_W-1:0] out_code;

  always #10 clk = ~clk;

  cal_code_formatter #(.RAW_W(RAW_W), .OUT_W(OUT_W), .SLOPE_EXP(SLOPE_EXP), .MODE_LEAD(MODE_LEAD)) uut (
    .clk(clk), .rst(rst), .cal_zero_valid(cal_zero_valid), .cal_fs_valid(cal_fs_valid),
    .cal_raw(cal_raw), .raw_valid(raw_valid), .raw_result(raw_result), .bipolar(bipolar),
    .cal_busy(cal_busy), .cal_err(cal_err), .out_valid(out_valid), .out_code(out_code)
  );

  int n_chk = 0;
  int n_fail = 0;
  longint m_off = 0, m_slope = 65536, m_cand = 0;
  bit m_err = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_code(input longint raw, input bit bp);
    longint r;
    r = ((raw - m_off) * m_slope + 32768) >>> 16;
    if (r > 131071) r = 131071;
    if (r < -131072) r = -131072;
    if (bp) r = r + 32768;
    if (r < 0) r = 0;
    if (r > 65535) r = 65535;
    return r;
  endfunction

  // Send one result and check both the write timing and the code (R8).
  task automatic convert(input longint raw, input bit bp, input bit flip, input string req);
    longint e;
    int early;
    e = exp_code(raw, bp);
    early = 0;
    @(negedge clk);
    raw_valid = 1'b1; raw_result = RAW_W'(raw); bipolar = bp;
    @(negedge clk);
    raw_valid = 1'b0;
    if (flip) bipolar = ~bp;
    if (out_valid) early++;
    for (int n = 1; n < MODE_LEAD; n++) begin
      @(negedge clk);
      if (out_valid) early++;
    end
    @(negedge clk);
    check(early == 0 && out_valid, "R8 write cycle", early * 2 + int'(out_valid), 1);
    check(out_code == e, req, out_code, e);
  endtask

  task automatic send_zero(input longint z);
    @(negedge clk);
    cal_zero_valid = 1'b1; cal_raw = RAW_W'(z);
    @(negedge clk);
    cal_zero_valid = 1'b0;
    m_cand = z;
  endtask

  task automatic send_fs(input longint fs);
    int len;
    @(negedge clk);
    cal_fs_valid = 1'b1; cal_raw = RAW_W'(fs);
    @(negedge clk);
    cal_fs_valid = 1'b0;
    len = 0;
    while (cal_busy && len < 100) begin
      len++;
      @(negedge clk);
    end
    if (fs > m_cand) begin
      m_off = m_cand;
      m_slope = (longint'(1) << 32) / (fs - m_cand);
      m_err = 1'b0;
      check(len == 34, "R3 busy length", len, 34);
    end else begin
      m_err = 1'b1;
      check(len == 0, "R4 no division on bad span", len, 0);
    end
    check(cal_err == m_err, "R4 cal_err", cal_err, m_err);
  endtask

  task automatic calibrate(input longint z, input longint fs);
    send_zero(z);
    send_fs(fs);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int quiet;
    rst = 1'b1;
    cal_zero_valid = 1'b0; cal_fs_valid = 1'b0; raw_valid = 1'b0; bipolar = 1'b0;
    cal_raw = '0; raw_result = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!out_valid && !cal_busy && !cal_err, "R1 flags", {out_valid, cal_busy, cal_err}, 0);
    check(out_code == 0, "R1 code", out_code, 0);

    // R1: identity coefficients before calibration
    convert(1234, 1'b0, 1'b0, "R1 unscaled");
    convert(-5, 1'b0, 1'b0, "R6 below zero");
    convert(-5, 1'b1, 1'b0, "R7 below zero");
    convert(100000, 1'b0, 1'b0, "R6 above range");
    convert(-200000, 1'b1, 1'b0, "R5 negative saturation");
    convert(200000, 1'b1, 1'b0, "R5 positive saturation");

    // R2: calibration and sweep in both modes, mode flipped after acceptance (R8)
    calibrate(-1000, 30000);
    for (longint r = -1600; r <= 31600; r += 830) begin
      convert(r, 1'b0, 1'b1, "R6 sweep");
      convert(r, 1'b1, 1'b1, "R7 sweep");
    end
    convert(-1000, 1'b0, 1'b0, "R6 offset point");
    convert(-1000, 1'b1, 1'b0, "R7 offset gives 8000h");
    convert(-1001, 1'b1, 1'b0, "R7 just below zero");
    convert(29999, 1'b0, 1'b0, "R6 near full scale");
    convert(30000, 1'b0, 1'b0, "R6 full scale");
    convert(14499, 1'b1, 1'b0, "R7 upper half");

    // R4: bad spans keep the old coefficients
    calibrate(500, 500);
    convert(12345, 1'b0, 1'b0, "R4 old coefficients kept");
    calibrate(500, -3);
    convert(-700, 1'b1, 1'b0, "R4 old coefficients kept");
    calibrate(-2000, 40000);
    convert(20000, 1'b0, 1'b0, "R2 recalibrated");

    // R9: second result replaces the first
    begin
      longint e;
      int early;
      e = exp_code(7000, 1'b1);
      @(negedge clk); raw_valid = 1'b1; raw_result = RAW_W'(3000); bipolar = 1'b0;
      @(negedge clk); raw_valid = 1'b0;
      repeat (9) @(negedge clk);
      raw_valid = 1'b1; raw_result = RAW_W'(7000); bipolar = 1'b1;
      @(negedge clk); raw_valid = 1'b0;
      early = int'(out_valid);
      for (int n = 1; n < MODE_LEAD; n++) begin
        @(negedge clk);
        if (out_valid) early++;
      end
      @(negedge clk);
      check(early == 0 && out_valid, "R9 single write", early * 2 + int'(out_valid), 1);
      check(out_code == e, "R9 newer code", out_code, e);
    end

    // R3: result and zero reading during division are ignored
    send_zero(-300);
    @(negedge clk); cal_fs_valid = 1'b1; cal_raw = RAW_W'(60000);
    @(negedge clk); cal_fs_valid = 1'b0;
    raw_valid = 1'b1; raw_result = RAW_W'(5000); cal_zero_valid = 1'b1; cal_raw = RAW_W'(7777);
    @(negedge clk); raw_valid = 1'b0; cal_zero_valid = 1'b0;
    quiet = 0;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (out_valid) quiet++;
    end
    check(quiet == 0, "R3 result ignored while busy", quiet, 0);
    m_off = -300;
    m_slope = (longint'(1) << 32) / 60300;
    convert(20000, 1'b0, 1'b0, "R3 zero reading ignored");
    send_fs(9000);
    convert(4000, 1'b1, 1'b0, "R3 candidate kept");

    // R5: span of one, saturation
    calibrate(5, 6);
    convert(4, 1'b0, 1'b0, "R5 span one below");
    convert(5, 1'b1, 1'b0, "R5 span one zero");
    convert(6, 1'b0, 1'b0, "R5 span one full");
    convert(4, 1'b1, 1'b0, "R5 span one negative");

    // R2: widest span
    calibrate(-524288, 524287);
    for (longint r = -524288; r <= 524287; r += 65521) begin
      convert(r, 1'b0, 1'b0, "R6 wide span");
      convert(r, 1'b1, 1'b0, "R7 wide span");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule